// File: doc/BRIEF.md
# Packed-Lane Rounding Variable Shifter

This block shifts every lane of a 64-bit data word by its own signed amount. The amount for each lane comes from the matching lane of a second 64-bit operand. A lane-size select splits the word into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. A signedness select picks between signed and unsigned lanes. A positive amount shifts the lane left. A negative amount shifts it right and rounds to nearest, with ties rounded upward. The amounts outside the lane width give fixed edge results.

The rounding constant is added at two bits more than the lane width, so the carry out of the lane top is never lost. The block holds one register stage. A word presented with `in_valid` high appears on `out_data` on the next clock, with `out_valid` high for that cycle. Between valid words the output register keeps the last result.

Top module: `rshift_unit`

## Requirements
- R1: `lane_sel` encodes the lane layout: 0 gives 8-bit lanes, 1 gives 16-bit lanes, 2 gives 32-bit lanes and 3 gives one 64-bit lane. Lane i occupies data bits [i*W +: W]. Each lane is computed only from its own data and shift lanes, and no bit passes between lanes.
- R2: The amount for a lane is bits [7:0] of its shift lane, read as a two's-complement value from -128 to 127. The other bits of the shift lane have no effect on the result.
- R3: For an amount a with 0 <= a < W, the result is the lane shifted left by a, and bits above the lane top are dropped. For a >= W, the result is zero.
- R4: For an amount -n with 1 <= n < W, the result is (lane + 2^(n-1)) shifted right by n. The sum is formed without loss of carry. The right shift is arithmetic for signed lanes and logical for unsigned lanes. Two examples: signed 64-bit 0x7FFFFFFFFFFFFFFF with amount -1 gives 0x4000000000000000, and unsigned 64-bit all-ones with amount -1 gives 0x8000000000000000.
- R5: For an amount of exactly -W on a signed lane, the result is ((lane >>> (W-1)) + 1) >>> 1. On an unsigned lane, the result is the lane's top bit moved to bit 0.
- R6: For an amount below -W, a signed lane gives its sign bit copied across the whole lane, and an unsigned lane gives zero.
- R7: `rst` is synchronous and active high, and it clears `out_valid` and `out_data`. After reset, `out_valid` equals the `in_valid` of the previous cycle. A word accepted in one cycle shows its result on `out_data` in the next cycle.
- R8: While `in_valid` is low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| op_data | input | 64 | Packed data lanes |
| op_shift | input | 64 | Packed shift lanes; the low byte of each lane is its amount |
| lane_sel | input | 2 | Lane size: 0=8, 1=16, 2=32, 3=64 bits |
| is_signed | input | 1 | 1 for signed lanes, 0 for unsigned lanes |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 64 | Registered packed result |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency and the holding of the result while the input is idle;
- the edge results of the single 64-bit lane: a zero amount passes the data through, an amount of 64 or more gives zero, and an amount below -64 gives zero or the copied sign bit.

Only the bench's sweep can show the following:
- the rounding arithmetic itself, including the carry at the lane top;
- the exact-minus-width rules;
- the independence of neighbouring lanes, and that the upper shift bits are ignored.

The sweep covers every amount from -128 to 127, every lane size and both signedness modes. The data patterns are zero, the lane maximum, the lane minimum, all-ones and random words, and the amounts differ from lane to lane.

// File: rtl/rshift_pkg.sv
package rshift_pkg;
  localparam int NUM_MODES = 4;
  localparam int MIN_LANE_W = 8;

  typedef enum logic [1:0] {
    LM_W8  = 2'd0,
    LM_W16 = 2'd1,
    LM_W32 = 2'd2,
    LM_W64 = 2'd3
  } lane_mode_e;

  function automatic int mode_lane_width(input int mode);
    return MIN_LANE_W << mode;
  endfunction
endpackage

// File: rtl/rshift_lane.sv
module rshift_lane #(
  parameter int W     = 8,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     d,
  input  logic [AMT_W-1:0] amt,
  input  logic             sgn,
  output logic [W-1:0]     q
);
  // two guard bits keep the rounding carry
  localparam int EW = W + 2;

  int                    a;
  int                    n;
  logic [EW-1:0]         ext;
  logic [EW-1:0]         sum;
  logic signed [EW-1:0]  shr;

  always_comb begin
    a   = int'($signed(amt));
    n   = -a;
    ext = sgn ? {{2{d[W-1]}}, d} : {2'b00, d};
    sum = '0;
    shr = '0;
    q   = '0;
    if (a >= 0) begin
      // left: overflow past the lane top is dropped
      if (a < W) q = d << a;
      else       q = '0;
    end else if (n > W) begin
      q = sgn ? {W{d[W-1]}} : '0;
    end else begin
      // n in 1..W: add half an LSB at extended width, then shift
      sum = ext + (EW'(1) << (n - 1));
      shr = $signed(sum) >>> n;
      q   = shr[W-1:0];
    end
  end
endmodule

// File: rtl/rshift_lane_array.sv
module rshift_lane_array #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] shift_i,
  input  logic              sgn_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int LANES = DATA_W / LANE_W;

  // upper shift-lane bits are deliberately ignored
  logic unused_shift_bits;
  assign unused_shift_bits = ^shift_i;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rshift_lane #(.W(LANE_W), .AMT_W(AMT_W)) u_lane (
      .d   (data_i[i*LANE_W +: LANE_W]),
      .amt (shift_i[i*LANE_W +: AMT_W]),
      .sgn (sgn_i),
      .q   (res_o[i*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/rshift_unit.sv
module rshift_unit
  import rshift_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int AMT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_data,
  input  logic [DATA_W-1:0] op_shift,
  input  logic [1:0]        lane_sel,
  input  logic              is_signed,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [NUM_MODES-1:0][DATA_W-1:0] mode_res;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
    rshift_lane_array #(
      .DATA_W (DATA_W),
      .LANE_W (mode_lane_width(g)),
      .AMT_W  (AMT_W)
    ) u_arr (
      .data_i  (op_data),
      .shift_i (op_shift),
      .sgn_i   (is_signed),
      .res_o   (mode_res[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= mode_res[lane_sel];
    end
  end

  // R7: valid follows the input one cycle later
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8: idle cycles keep the result
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  // R3: zero amount on the single wide lane passes data unchanged
  assert_zero_amt_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_sel == LM_W64 && op_shift[AMT_W-1:0] == '0)
      |=> out_data == $past(op_data));
  // R3: amount at or beyond the width clears the wide lane
  assert_left_big_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_sel == LM_W64 && !op_shift[AMT_W-1]
       && int'(op_shift[AMT_W-1:0]) >= DATA_W)
      |=> out_data == '0);
  // R6: below minus width, unsigned gives zero
  assert_uns_below_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_sel == LM_W64 && !is_signed
       && int'($signed(op_shift[AMT_W-1:0])) < -DATA_W)
      |=> out_data == '0);
  // R6: below minus width, signed replicates the sign
  assert_sgn_below_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_sel == LM_W64 && is_signed
       && int'($signed(op_shift[AMT_W-1:0])) < -DATA_W)
      |=> out_data == {DATA_W{$past(op_data[DATA_W-1])}});
endmodule

// File: tb/sim_rshift_unit.sv
module sim_rshift_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_data = '0;
  logic [63:0] op_shift = '0;
  logic [1:0]  lane_sel = '0;
  logic        is_signed = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic        pend_valid = 1'b0;
  logic [63:0] exp_data   = '0;
  string       pend_tag   = "R7";

  always #5 clk = ~clk;

  rshift_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_data(op_data),
    .op_shift(op_shift), .lane_sel(lane_sel), .is_signed(is_signed),
    .out_valid(out_valid), .out_data(out_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired (R7) actual=%0d cycles expected<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // behavioural reference at wide precision
  function automatic logic [63:0] ref_vec(input logic [63:0] d, input logic [63:0] s,
                                          input int sel, input bit sg);
    int w = 8 << sel;
    logic [63:0] res = '0;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int i = 0; i < 64 / w; i++) begin
      logic [63:0] ld = (d >> (i * w)) & mask;
      int a = int'($signed(s[i*w +: 8]));
      logic signed [65:0] v = $signed({2'b00, ld});
      logic signed [65:0] r;
      if (sg && ld[w-1]) v = v - (66'sd1 <<< w);
      if (a >= 0)        r = (a >= w) ? 66'sd0 : (v <<< a);
      else if (-a > w)   r = sg ? ((v < 0) ? -66'sd1 : 66'sd0) : 66'sd0;
      else if (-a == w)  r = sg ? (((v >>> (w - 1)) + 66'sd1) >>> 1) : (v >>> (w - 1));
      else               r = (v + (66'sd1 <<< (-a - 1))) >>> (-a);
      res = res | ((r[63:0] & mask) << (i * w));
    end
    return res;
  endfunction

  function automatic string classify(input int a, input int w);
    if (a >= 0)  return "R3";
    if (-a < w)  return "R4";
    if (-a == w) return "R5";
    return "R6";
  endfunction

  task automatic check_out();
    n_tests++;
    if (out_valid !== pend_valid) begin
      n_fail++;
      $display("FAIL R7 out_valid actual=%0b expected=%0b", out_valid, pend_valid);
    end else if (out_data !== exp_data) begin
      n_fail++;
      $display("FAIL %s out_data actual=%h expected=%h", pend_tag, out_data, exp_data);
    end
  endtask

  task automatic step(input bit v, input logic [63:0] d, input logic [63:0] s,
                      input int sel, input bit sg, input string tag);
    @(negedge clk);
    check_out();
    in_valid  = v;
    op_data   = d;
    op_shift  = s;
    lane_sel  = 2'(sel);
    is_signed = sg;
    pend_valid = v;
    if (v) begin
      exp_data = ref_vec(d, s, sel, sg);
      pend_tag = tag;
    end else begin
      pend_tag = "R8";
    end
  endtask

  function automatic logic [63:0] rep(input logic [63:0] lane, input int w);
    logic [63:0] r = '0;
    for (int i = 0; i < 64 / w; i++) r = r | (lane << (i * w));
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || out_data !== 64'd0) begin
      n_fail++;
      $display("FAIL R7 reset actual=%0b/%h expected=0/0", out_valid, out_data);
    end
    rst = 1'b0;
    pend_valid = 1'b0;
    exp_data = '0;

    // R4 explicit carry examples
    step(1'b1, 64'h7FFFFFFFFFFFFFFF, {56'hABCDEF, 8'hFF}, 3, 1'b1, "R4 signed max >> 1");
    step(1'b1, 64'hFFFFFFFFFFFFFFFF, {56'h123456, 8'hFF}, 3, 1'b0, "R4 unsigned ones >> 1");
    step(1'b0, '0, '0, 3, 1'b0, "R8");
    step(1'b0, 64'hDEAD, 64'h1, 0, 1'b1, "R8");

    for (int sel = 0; sel < 4; sel++) begin
      int w = 8 << sel;
      logic [63:0] lmask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      for (int sg = 0; sg < 2; sg++) begin
        for (int p = 0; p < 5; p++) begin
          logic [63:0] d;
          case (p)
            0: d = '0;
            1: d = rep(lmask >> 1, w);
            2: d = rep((lmask >> 1) + 64'd1, w);
            3: d = '1;
            default: d = {$urandom, $urandom};
          endcase
          for (int a = -128; a < 128; a++) begin
            logic [63:0] s = {$urandom, $urandom};
            string tag;
            for (int i = 0; i < 64 / w; i++)
              s[i*w +: 8] = 8'(p == 4 ? a + i * 23 : a);
            tag = (p == 4) ? "R1 R2 mixed lanes" : {"R2 ", classify(a, w)};
            step(1'b1, d, s, sel, sg[0], tag);
            if (((a + 128) % 97) == 0) step(1'b0, ~d, ~s, sel, sg[0], "R8");
          end
        end
      end
    end

    step(1'b0, '0, '0, 0, 1'b0, "R8");
    step(1'b0, '0, '0, 0, 1'b0, "R8");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule